// File: doc/BRIEF.md
# Prioritised Multi-Rate Status Blinker

This block drives a single active-low, open-drain status flag of a battery charger. It takes an input-supply validity bit, the charger enable bit and seven event flags, and reduces them to one of three pad behaviours: released (high impedance), pulled low steadily, or toggling between pulled low and released. Each event has its own toggle rate. A higher rate means a more urgent condition, so when several events are active together only the fastest one is shown.

All rates come from one system clock whose frequency is a parameter. Each half period is rounded to the nearest whole clock cycle. The output `pull_low_o` is the enable of an external open-drain driver. The flag is never driven high, so toggling always means alternating between pulling low and letting go.

A new display pattern always starts from a clean phase. An end-of-charge indication stays latched while the supply remains valid, so the slowest blink keeps going until the input goes away. When a faster event clears, the display drops back to whatever slower event is still active.

Top module: `blink_status_flag`

## Requirements
- R1: While `rst_ni` is low, `pull_low_o` is 0 (flag released).
- R2: If `in_valid_i` is 0 at a clock edge, `pull_low_o` is 0 after that edge, whatever the other inputs are.
- R3: If `in_valid_i` is 1 and `chg_en_i` is 0 at a clock edge, `pull_low_o` is 1 after that edge, whatever the event flags are.
- R4: If the input is valid, the charger is enabled, and no event is active or latched, `pull_low_o` is held at 1.
- R5: Event bit positions and rates in `evt_i`: bit 0 end of charge 4.1 Hz, bit 1 charging 6.2 Hz, bit 2 overcharge 8.2 Hz, bit 3 charge timeout 10.2 Hz, bit 4 below pre-charge threshold after fast start 12.8 Hz, bit 5 thermal warning 14.2 Hz, bit 6 battery temperature fault 16.2 Hz. A shown event toggles with 50% duty. Each half period lasts round(CLK_HZ / (2·rate)) cycles.
- R6: When several event bits are active, only the highest-numbered (fastest) one is shown.
- R7: When the shown event clears while a slower event is still active, the slower event's pattern is shown from the next clock edge.
- R8: Whenever the shown pattern changes to a blinking event, the flag is pulled low for one full half period of the new rate, starting one cycle after the change in inputs.
- R9: Once bit 0 is seen while the input is valid, end-of-charge blinking continues after bit 0 drops. It stops only when `in_valid_i` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input supply within its valid window and above the battery |
| chg_en_i | input | 1 | Charger enable state |
| evt_i | input | 7 | Event flags, bit order as in R5 |
| pull_low_o | output | 1 | 1 = open-drain driver pulls the flag low |

## Verification
The bench measures every rate over two full half periods and counts the exact cycle of each edge. An off-by-one in the rounding or the terminal count shows up as an edge one cycle early or late. It changes the shown event while the old pattern is in its released half, so a design that skips the phase restart starts the new rate released instead of low. It drops the end-of-charge bit in the middle of a blink: a design without the latch falls back to a steady low, and one that never clears the latch keeps blinking after the supply goes invalid and returns. Random combinations of validity, enable and sparse event sets check that enable-low and no-event both give a steady low, and that the fastest active bit always wins.

// File: rtl/blink_pkg.sv
package blink_pkg;

  localparam int NUM_EVT = 7;
  localparam int IDX_W   = $clog2(NUM_EVT);

  typedef struct packed {
    logic             released;  // flag let go (high impedance)
    logic             blink;     // toggling pattern active
    logic [IDX_W-1:0] idx;       // event shown when blinking
  } mode_t;

  localparam mode_t MODE_OFF  = '{released: 1'b1, blink: 1'b0, idx: '0};
  localparam mode_t MODE_HOLD = '{released: 1'b0, blink: 1'b0, idx: '0};

  // toggle rate in tenths of a hertz, index = event bit
  function automatic int unsigned rate_dhz(int idx);
    case (idx)
      1:       return 62;
      2:       return 82;
      3:       return 102;
      4:       return 128;
      5:       return 142;
      6:       return 162;
      default: return 41;
    endcase
  endfunction

  // half period in clock cycles, rounded to nearest
  function automatic int unsigned half_cycles(int unsigned clk_hz, int idx);
    longint unsigned num;
    longint unsigned den;
    num = longint'(clk_hz) * 10 + longint'(rate_dhz(idx));
    den = 2 * longint'(rate_dhz(idx));
    return int'(num / den);
  endfunction

endpackage

// File: rtl/blink_prio_sel.sv
module blink_prio_sel
  import blink_pkg::*;
(
  input  logic               in_valid_i,
  input  logic               chg_en_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               eoc_keep_i,
  output mode_t              mode_o
);

  logic [NUM_EVT-1:0] evt_eff;
  logic [IDX_W-1:0]   top_idx;
  logic               any_evt;

  assign evt_eff = evt_i | {{(NUM_EVT-1){1'b0}}, eoc_keep_i};

  // last hit wins, so the highest bit (fastest rate) has priority
  always_comb begin
    top_idx = '0;
    any_evt = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt_eff[i]) begin
        top_idx = IDX_W'(i);
        any_evt = 1'b1;
      end
    end
  end

  always_comb begin
    if (!in_valid_i)                mode_o = MODE_OFF;
    else if (!chg_en_i || !any_evt) mode_o = MODE_HOLD;
    else mode_o = '{released: 1'b0, blink: 1'b1, idx: top_idx};
  end

endmodule

// File: rtl/blink_rate_gen.sv
module blink_rate_gen
  import blink_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_000_000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  output mode_t mode_o,
  output logic  pull_low_o
);

  localparam int unsigned HALF_MAX = half_cycles(CLK_HZ, 0);
  localparam int          CNT_W    = $clog2(HALF_MAX + 1);
  localparam int          LUT_N    = 2 ** IDX_W;

  logic [CNT_W-1:0] half_lut [LUT_N];

  for (genvar g = 0; g < LUT_N; g++) begin : g_lut
    assign half_lut[g] = CNT_W'(half_cycles(CLK_HZ, g));
  end

  mode_t            mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;  // 1 = pulling low
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = half_lut[mode_q.idx] - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (mode_i != mode_q) begin
        // new pattern starts with a full low half
        cnt_q   <= '0;
        phase_q <= 1'b1;
      end else if (cnt_q == last_cnt) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign mode_o     = mode_q;
  assign pull_low_o = mode_q.released ? 1'b0 : (mode_q.blink ? phase_q : 1'b1);

endmodule

// File: rtl/blink_status_flag.sv
module blink_status_flag
  import blink_pkg::*;
#(
  parameter int unsigned CLK_HZ = 1_000_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic               chg_en_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               pull_low_o
);

  logic  eoc_keep_q;
  mode_t next_mode;
  mode_t shown_mode;

  // end of charge stays shown until the supply goes away
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          eoc_keep_q <= 1'b0;
    else if (!in_valid_i) eoc_keep_q <= 1'b0;
    else if (evt_i[0])    eoc_keep_q <= 1'b1;
  end

  blink_prio_sel u_sel (
    .in_valid_i (in_valid_i),
    .chg_en_i   (chg_en_i),
    .evt_i      (evt_i),
    .eoc_keep_i (eoc_keep_q),
    .mode_o     (next_mode)
  );

  blink_rate_gen #(.CLK_HZ(CLK_HZ)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (next_mode),
    .mode_o     (shown_mode),
    .pull_low_o (pull_low_o)
  );

endmodule

// File: rtl/blink_status_flag_chk.sv
module blink_status_flag_chk
  import blink_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  in_valid_i,
  input logic  chg_en_i,
  input logic  evt_top_i,
  input logic  pull_low_o,
  input mode_t shown_mode
);

  // R2
  p_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!in_valid_i) |-> (shown_mode.released && !pull_low_o));

  // R3
  p_hold_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && !chg_en_i) |-> pull_low_o);

  // R6
  p_top_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(in_valid_i && chg_en_i && evt_top_i)
      |-> (shown_mode.blink && shown_mode.idx == IDX_W'(NUM_EVT - 1)));

  // R8
  p_restart_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shown_mode.blink && shown_mode != $past(shown_mode)) |-> pull_low_o);

endmodule

bind blink_status_flag blink_status_flag_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .chg_en_i   (chg_en_i),
  .evt_top_i  (evt_i[blink_pkg::NUM_EVT-1]),
  .pull_low_o (pull_low_o),
  .shown_mode (shown_mode)
);

// File: tb/blink_status_flag_test.sv
module blink_status_flag_test;

  localparam int unsigned CLK_HZ = 10_000;
  localparam int          NEV    = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           chg_en = 1'b1;
  logic [NEV-1:0] evt = '0;
  logic           pull_low;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blink_status_flag #(.CLK_HZ(CLK_HZ)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .chg_en_i   (chg_en),
    .evt_i      (evt),
    .pull_low_o (pull_low)
  );

  // R5 rates in Hz
  function automatic int half_of(int idx);
    real r [NEV] = '{4.1, 6.2, 8.2, 10.2, 12.8, 14.2, 16.2};
    return $rtoi(real'(CLK_HZ) / (2.0 * r[idx]) + 0.5);
  endfunction

  // -2 released, -1 steady low, else shown event index
  function automatic int exp_mode(bit v, bit e, logic [NEV-1:0] ev);
    int m = -1;
    if (!v) return -2;
    if (!e) return -1;
    for (int i = 0; i < NEV; i++) if (ev[i]) m = i;
    return m;
  endfunction

  function automatic bit exp_pull(int m, int j);
    if (m == -2) return 1'b0;
    if (m == -1) return 1'b1;
    return ((j / half_of(m)) % 2) == 0;
  endfunction

  task automatic drive(bit v, bit e, logic [NEV-1:0] ev);
    in_valid = v;
    chg_en   = e;
    evt      = ev;
  endtask

  // called at a negedge just after driving; sample j = cycles after update edge
  task automatic check_window(int m, int n, int j0, string tag);
    int bad = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (pull_low !== exp_pull(m, j + j0)) begin
        if (bad == 0)
          $display("FAIL %s: sample %0d pull_low=%0b expected %0b",
                   tag, j + j0, pull_low, exp_pull(m, j + j0));
        bad++;
      end
    end
    nchk++;
    if (bad != 0) nerr++;
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int m;
    logic [NEV-1:0] rev;
    bit rv, re;
    void'($urandom(32'd20240611));

    // R1 reset state
    drive(1'b1, 1'b1, 7'h7F);
    repeat (3) @(negedge clk);
    nchk++;
    if (pull_low !== 1'b0) begin
      nerr++;
      $display("FAIL R1: pull_low=%0b expected 0", pull_low);
    end
    drive(1'b0, 1'b1, 7'h7F);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 invalid input releases despite events
    drive(1'b0, 1'b1, 7'h7F);
    check_window(-2, 50, 0, "R2");
    // R4 valid, enabled, no event
    drive(1'b1, 1'b1, 7'h00);
    check_window(-1, 700, 0, "R4");
    // R3 disabled overrides every event
    drive(1'b1, 1'b0, 7'h7F);
    check_window(-1, 700, 0, "R3");

    // R5 each rate alone
    for (int i = 0; i < NEV; i++) begin
      drive(1'b1, 1'b0, 7'h00);
      check_window(-1, 2, 0, "R5 pre");
      drive(1'b1, 1'b1, NEV'(1) << i);
      check_window(i, 2 * half_of(i) + 5, 0, $sformatf("R5 bit%0d", i));
    end
    drive(1'b0, 1'b1, 7'h00);
    check_window(-2, 2, 0, "R2 clear");

    // R6 fastest wins
    drive(1'b1, 1'b1, 7'b1000100);
    check_window(6, 2 * half_of(6) + 3, 0, "R6 a");
    drive(1'b1, 1'b0, 7'h00);
    check_window(-1, 2, 0, "R6 pre");
    drive(1'b1, 1'b1, 7'b0011010);
    check_window(4, 2 * half_of(4) + 3, 0, "R6 b");

    // R7/R8 fallback while old pattern is in its released half
    drive(1'b1, 1'b1, 7'b0100100);
    check_window(5, 400, 0, "R7 fast");
    drive(1'b1, 1'b1, 7'b0000100);
    check_window(2, 2 * half_of(2) + 4, 0, "R7 R8 fallback restart");

    // R9 end-of-charge latch
    drive(1'b0, 1'b1, 7'h00);
    check_window(-2, 2, 0, "R9 clear");
    drive(1'b1, 1'b1, 7'h01);
    check_window(0, 5, 0, "R9 start");
    drive(1'b1, 1'b1, 7'h00);
    check_window(0, 2 * half_of(0) + 5, 5, "R9 kept");
    drive(1'b0, 1'b1, 7'h00);
    check_window(-2, 3, 0, "R9 invalid");
    drive(1'b1, 1'b1, 7'h00);
    check_window(-1, half_of(0) + 300, 0, "R9 latch cleared");

    // random mix, each step from a released state
    for (int k = 0; k < 30; k++) begin
      drive(1'b0, 1'b1, 7'h00);
      check_window(-2, 2, 0, "R2 rnd");
      rv  = ($urandom % 5) != 0;
      re  = ($urandom % 4) != 0;
      rev = NEV'($urandom & $urandom & $urandom);
      m = exp_mode(rv, re, rev);
      drive(rv, re, rev);
      check_window(m, (m >= 0) ? 2 * half_of(m) + 3 : 20, 0,
                   $sformatf("R6 rnd v=%0b e=%0b ev=%b", rv, re, rev));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule